// File: doc/BRIEF.md
# Serial Link Control Register Bank

This block is the software-visible control and status register file of a serial link controller. A simple word-addressed bus writes and reads 32-bit registers at byte offsets. The bank holds the link's soft-reset and enable controls, each of which can be handed either to software or to an internally generated value. It also holds the power-state request and force bits, the error-handling policy bits, a microsecond tick count and the short/long packet threshold, and it drives each of these on a dedicated output.

Event pulses from the link (header ECC failures, CRC failures, observed reset and wake, power-state entry) are latched into write-one-to-clear status bits. An interrupt enable mask gates them onto a single registered interrupt line. Two read-only windows expose the link state machines' current states and one of eight 32-bit debug signal groups picked by a select register. Reads are combinational on the address, and unmapped offsets read as zero.

Top module: `lnkcsr_top`

## Requirements
- R1: After reset, offset 0x00 reads 0x1, 0x04 reads 0x0, 0x08 reads 0x0, 0x0C reads 0x0F, 0x10 reads 0x0, 0x14 reads 0x5, 0x18 reads 0x26, 0x1C reads 0x2F, 0x3C reads 0x0, and `irq` is 0.
- R2: Offsets 0x00 and 0x04 hold a control bit in [0] and a source select in [1]. When the select is 0, `swreset_out` / `enable_out` follow `hw_swreset` / `hw_enable`. When the select is 1, they follow the register bit.
- R3: A one-cycle pulse on `evt_pulse[i]` sets status bit i at offset 0x08 from the next cycle on. The bits are ECC uncorrectable [0], ECC corrected [1], CRC mismatch [2], reset observed [3], wake observed [4] and power-state entry [5].
- R4: Writing offset 0x08 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged.
- R5: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R6: Offset 0x0C holds a 6-bit interrupt enable mask. `irq` is 1 in the cycle after a cycle in which any status bit and its enable are both 1, and 0 otherwise.
- R7: Offset 0x10 holds P1/P2/P3 requests in [2:0], a forced link reset in [30] and a forced wake in [31], driven on `pwr_req`, `link_reset_force` and `link_wake_force`. Bits [29:3] read 0 and ignore writes.
- R8: Offset 0x18 keeps only write-data bits [9:0] and offset 0x1C keeps only bits [7:0]. Their upper bits read 0, and the values drive `us_tick_count` and `short_pkt_max`.
- R9: Offset 0x38 is read-only and reads `train_state` in [4:0], `tx_state` in [11:8], `rx_state` in [15:12] and `deskew_state` in [17:16], with other bits 0.
- R10: Offset 0x3C holds a 3-bit select in [2:0]. Offset 0x40 reads `dbg_groups[32*sel +: 32]` and ignores writes.
- R11: Reads of any offset not listed return 0, and writes to such offsets change no register or output.
- R12: Offset 0x14 holds four policy bits in [3:0], driven on `err_policy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Write strobe |
| csr_addr | input | 8 | Byte address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data for `csr_addr` (combinational) |
| evt_pulse | input | 6 | One-cycle event pulses to latch |
| hw_swreset | input | 1 | Internally generated soft-reset value |
| hw_enable | input | 1 | Internally generated enable value |
| swreset_out | output | 1 | Selected soft-reset control |
| enable_out | output | 1 | Selected enable control |
| pwr_req | output | 3 | P1/P2/P3 requests |
| link_reset_force | output | 1 | Forced link reset |
| link_wake_force | output | 1 | Forced wake to P0 |
| err_policy | output | 4 | Error policy bits |
| us_tick_count | output | 10 | Clock cycles per microsecond |
| short_pkt_max | output | 8 | Short/long packet threshold |
| train_state | input | 5 | Link training state |
| tx_state | input | 4 | Transmit link-layer state |
| rx_state | input | 4 | Receive link-layer state |
| deskew_state | input | 2 | Deskew state |
| dbg_groups | input | 256 | Eight 32-bit debug groups |
| irq | output | 1 | Registered interrupt |

## Verification
The hardest situation to reach is a clearing write that lands in the same cycle as a fresh event pulse on the same status bit. The bench drives a write of all ones to the status offset together with a pulse on every event line and reads the status back on the next cycle. It then repeats the collision on partial masks during a long stretch of random writes mixed with random pulses. A behavioural model compares every output and the read word on every clock, so the one-cycle lag of the interrupt behind the status and enables is checked at each transition.

// File: rtl/lnkcsr_pkg.sv
package lnkcsr_pkg;

    localparam int DATA_W   = 32;
    localparam int NUM_EVT  = 6;
    localparam int US_W     = 10;
    localparam int SPKT_W   = 8;
    localparam int POL_W    = 4;
    localparam int PREQ_W   = 3;

    // byte offsets
    localparam logic [7:0] OFS_SWRST = 8'h00;
    localparam logic [7:0] OFS_ENA   = 8'h04;
    localparam logic [7:0] OFS_ISTAT = 8'h08;
    localparam logic [7:0] OFS_IEN   = 8'h0C;
    localparam logic [7:0] OFS_PWR   = 8'h10;
    localparam logic [7:0] OFS_POL   = 8'h14;
    localparam logic [7:0] OFS_USCNT = 8'h18;
    localparam logic [7:0] OFS_SPKT  = 8'h1C;
    localparam logic [7:0] OFS_STATE = 8'h38;
    localparam logic [7:0] OFS_DSEL  = 8'h3C;
    localparam logic [7:0] OFS_DOBS  = 8'h40;

    typedef struct packed {
        logic                 val;
        logic                 use_reg;
    } ctl_mux_t;

    typedef struct packed {
        ctl_mux_t             swrst;
        ctl_mux_t             ena;
        logic [NUM_EVT-1:0]   int_en;
        logic [PREQ_W-1:0]    preq;
        logic                 lnk_rst;
        logic                 lnk_wake;
        logic [POL_W-1:0]     pol;
        logic [US_W-1:0]      us_cnt;
        logic [SPKT_W-1:0]    spkt;
        logic [2:0]           dsel;
    } cfg_t;

    typedef struct packed {
        logic [1:0] deskew;
        logic [3:0] rx;
        logic [3:0] tx;
        logic [4:0] train;
    } link_state_t;

    function automatic cfg_t cfg_default();
        cfg_t c;
        c.swrst   = '{val: 1'b1, use_reg: 1'b0};
        c.ena     = '{val: 1'b0, use_reg: 1'b0};
        c.int_en  = 6'b00_1111;
        c.preq    = '0;
        c.lnk_rst = 1'b0;
        c.lnk_wake= 1'b0;
        c.pol     = 4'b0101;
        c.us_cnt  = 10'h026;
        c.spkt    = 8'h2F;
        c.dsel    = '0;
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_state(link_state_t s);
        logic [DATA_W-1:0] w;
        w        = '0;
        w[4:0]   = s.train;
        w[11:8]  = s.tx;
        w[15:12] = s.rx;
        w[17:16] = s.deskew;
        return w;
    endfunction

endpackage

// File: rtl/lnkcsr_ovr.sv
module lnkcsr_ovr #(
    parameter int N = 2
) (
    input  logic [N-1:0] reg_val,
    input  logic [N-1:0] use_reg,
    input  logic [N-1:0] hw_val,
    output logic [N-1:0] ctl_out
);
    for (genvar i = 0; i < N; i++) begin : g_sel
        assign ctl_out[i] = use_reg[i] ? reg_val[i] : hw_val[i];
    end
endmodule

// File: rtl/lnkcsr_irq.sv
module lnkcsr_irq #(
    parameter int NEV = 6
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NEV-1:0] evt,
    input  logic [NEV-1:0] clr,
    input  logic [NEV-1:0] en,
    output logic [NEV-1:0] status,
    output logic           irq
);
    logic [NEV-1:0] st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            irq  <= 1'b0;
        end else begin
            st_q <= (st_q & ~clr) | evt;
            irq  <= |(st_q & en);
        end
    end

    assign status = st_q;

    // R3: a pulse is latched
    p_evt_sets_r3: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((st_q & $past(evt)) == $past(evt)));

    // R4: cleared bits without a concurrent pulse drop
    p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (|(clr & ~evt)) |=> ((st_q & $past(clr & ~evt)) == '0));

    // R5: pulse wins over clear
    p_evt_wins_r5: assert property (@(posedge clk) disable iff (rst)
        (|(clr & evt)) |=> ((st_q & $past(clr & evt)) == $past(clr & evt)));

    // R6: no enabled pending bit means no interrupt next cycle
    p_irq_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        ((st_q & en) == '0) |=> !irq);
endmodule

// File: rtl/lnkcsr_rdmux.sv
module lnkcsr_rdmux
    import lnkcsr_pkg::*;
#(
    parameter int AW    = 8,
    parameter int SEL_W = 3
) (
    input  logic [AW-1:0]                 addr,
    input  cfg_t                          cfg,
    input  logic [NUM_EVT-1:0]            status,
    input  link_state_t                   lstate,
    input  logic [(DATA_W<<SEL_W)-1:0]    dbg,
    output logic [DATA_W-1:0]             rdata,
    output logic                          hit
);
    localparam int NGRP = 1 << SEL_W;

    logic [DATA_W-1:0] grp [NGRP];

    for (genvar g = 0; g < NGRP; g++) begin : g_dbg
        assign grp[g] = dbg[g*DATA_W +: DATA_W];
    end

    always_comb begin
        rdata = '0;
        hit   = 1'b1;
        case (addr)
            AW'(OFS_SWRST): rdata[1:0] = {cfg.swrst.use_reg, cfg.swrst.val};
            AW'(OFS_ENA):   rdata[1:0] = {cfg.ena.use_reg, cfg.ena.val};
            AW'(OFS_ISTAT): rdata[NUM_EVT-1:0] = status;
            AW'(OFS_IEN):   rdata[NUM_EVT-1:0] = cfg.int_en;
            AW'(OFS_PWR): begin
                rdata[PREQ_W-1:0] = cfg.preq;
                rdata[30]         = cfg.lnk_rst;
                rdata[31]         = cfg.lnk_wake;
            end
            AW'(OFS_POL):   rdata[POL_W-1:0]  = cfg.pol;
            AW'(OFS_USCNT): rdata[US_W-1:0]   = cfg.us_cnt;
            AW'(OFS_SPKT):  rdata[SPKT_W-1:0] = cfg.spkt;
            AW'(OFS_STATE): rdata = pack_state(lstate);
            AW'(OFS_DSEL):  rdata[SEL_W-1:0]  = cfg.dsel[SEL_W-1:0];
            AW'(OFS_DOBS):  rdata = grp[cfg.dsel[SEL_W-1:0]];
            default:        hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/lnkcsr_top.sv
module lnkcsr_top
    import lnkcsr_pkg::*;
#(
    parameter int AW    = 8,
    parameter int SEL_W = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        csr_we,
    input  logic [AW-1:0]               csr_addr,
    input  logic [DATA_W-1:0]           csr_wdata,
    output logic [DATA_W-1:0]           csr_rdata,
    input  logic [NUM_EVT-1:0]          evt_pulse,
    input  logic                        hw_swreset,
    input  logic                        hw_enable,
    output logic                        swreset_out,
    output logic                        enable_out,
    output logic [PREQ_W-1:0]           pwr_req,
    output logic                        link_reset_force,
    output logic                        link_wake_force,
    output logic [POL_W-1:0]            err_policy,
    output logic [US_W-1:0]             us_tick_count,
    output logic [SPKT_W-1:0]           short_pkt_max,
    input  logic [4:0]                  train_state,
    input  logic [3:0]                  tx_state,
    input  logic [3:0]                  rx_state,
    input  logic [1:0]                  deskew_state,
    input  logic [(DATA_W<<SEL_W)-1:0]  dbg_groups,
    output logic                        irq
);
    localparam int NCTL = 2;

    cfg_t               cfg_q;
    logic [NUM_EVT-1:0] status;
    logic [NUM_EVT-1:0] clr;
    link_state_t        lstate;
    logic               rd_hit;
    logic [NCTL-1:0]    ctl_sel;

    // register writes
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= cfg_default();
        end else if (csr_we) begin
            case (csr_addr)
                AW'(OFS_SWRST): cfg_q.swrst <= '{val: csr_wdata[0], use_reg: csr_wdata[1]};
                AW'(OFS_ENA):   cfg_q.ena   <= '{val: csr_wdata[0], use_reg: csr_wdata[1]};
                AW'(OFS_IEN):   cfg_q.int_en <= csr_wdata[NUM_EVT-1:0];
                AW'(OFS_PWR): begin
                    cfg_q.preq     <= csr_wdata[PREQ_W-1:0];
                    cfg_q.lnk_rst  <= csr_wdata[30];
                    cfg_q.lnk_wake <= csr_wdata[31];
                end
                AW'(OFS_POL):   cfg_q.pol    <= csr_wdata[POL_W-1:0];
                AW'(OFS_USCNT): cfg_q.us_cnt <= csr_wdata[US_W-1:0];
                AW'(OFS_SPKT):  cfg_q.spkt   <= csr_wdata[SPKT_W-1:0];
                AW'(OFS_DSEL):  cfg_q.dsel   <= 3'(csr_wdata[SEL_W-1:0]);
                default: ;
            endcase
        end
    end

    assign clr = (csr_we && csr_addr == AW'(OFS_ISTAT)) ? csr_wdata[NUM_EVT-1:0] : '0;

    lnkcsr_irq #(.NEV(NUM_EVT)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .evt    (evt_pulse),
        .clr    (clr),
        .en     (cfg_q.int_en),
        .status (status),
        .irq    (irq)
    );

    lnkcsr_ovr #(.N(NCTL)) u_ovr (
        .reg_val ({cfg_q.ena.val, cfg_q.swrst.val}),
        .use_reg ({cfg_q.ena.use_reg, cfg_q.swrst.use_reg}),
        .hw_val  ({hw_enable, hw_swreset}),
        .ctl_out (ctl_sel)
    );

    assign swreset_out = ctl_sel[0];
    assign enable_out  = ctl_sel[1];

    assign lstate = '{deskew: deskew_state, rx: rx_state, tx: tx_state, train: train_state};

    lnkcsr_rdmux #(.AW(AW), .SEL_W(SEL_W)) u_rd (
        .addr   (csr_addr),
        .cfg    (cfg_q),
        .status (status),
        .lstate (lstate),
        .dbg    (dbg_groups),
        .rdata  (csr_rdata),
        .hit    (rd_hit)
    );

    assign pwr_req          = cfg_q.preq;
    assign link_reset_force = cfg_q.lnk_rst;
    assign link_wake_force  = cfg_q.lnk_wake;
    assign err_policy       = cfg_q.pol;
    assign us_tick_count    = cfg_q.us_cnt;
    assign short_pkt_max    = cfg_q.spkt;

    // R1: soft reset asserted, enable cleared right after reset
    p_rstval_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_q.swrst.val && !cfg_q.ena.val && !irq));

    // R7: reserved power-control bits read as zero
    p_rsvd_zero_r7: assert property (@(posedge clk) disable iff (rst)
        (csr_addr == AW'(OFS_PWR)) |-> (csr_rdata[29:3] == '0));

    // R11: unmapped offsets read as zero
    p_unmapped_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |-> (csr_rdata == '0));

    // R2: register source selected means output is stable without a write
    p_ovr_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.swrst.use_reg && !csr_we) |=> $stable(swreset_out));
endmodule

// File: tb/sim_lnkcsr_top.sv
module sim_lnkcsr_top;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         we  = 1'b0;
    logic [7:0]   addr = '0;
    logic [31:0]  wdata = '0;
    logic [31:0]  rdata;
    logic [5:0]   ev = '0;
    logic         hw_sr = 1'b0, hw_en = 1'b0;
    logic         sr_o, en_o, lr_o, lw_o, irq;
    logic [2:0]   preq_o;
    logic [3:0]   pol_o;
    logic [9:0]   us_o;
    logic [7:0]   sp_o;
    logic [4:0]   trn = '0;
    logic [3:0]   txs = '0, rxs = '0;
    logic [1:0]   dsk = '0;
    logic [255:0] dbg = '0;

    int checks = 0, fails = 0, cyc = 0;
    string phase_tag = "";

    always #5ns clk = ~clk;

    lnkcsr_top u0 (
        .clk(clk), .rst(rst), .csr_we(we), .csr_addr(addr), .csr_wdata(wdata),
        .csr_rdata(rdata), .evt_pulse(ev), .hw_swreset(hw_sr), .hw_enable(hw_en),
        .swreset_out(sr_o), .enable_out(en_o), .pwr_req(preq_o),
        .link_reset_force(lr_o), .link_wake_force(lw_o), .err_policy(pol_o),
        .us_tick_count(us_o), .short_pkt_max(sp_o), .train_state(trn),
        .tx_state(txs), .rx_state(rxs), .deskew_state(dsk), .dbg_groups(dbg),
        .irq(irq)
    );

    // behavioural reference state
    bit        m_sw, m_swsel, m_en, m_ensel, m_lr, m_lw, m_irq;
    bit [5:0]  m_st, m_ien, m_clr;
    bit [2:0]  m_preq, m_dsel;
    bit [3:0]  m_pol;
    bit [9:0]  m_us;
    bit [7:0]  m_sp;

    task automatic model_reset();
        m_sw = 1; m_swsel = 0; m_en = 0; m_ensel = 0; m_lr = 0; m_lw = 0;
        m_irq = 0; m_st = 0; m_ien = 6'h0F; m_preq = 0; m_dsel = 0;
        m_pol = 4'h5; m_us = 10'h26; m_sp = 8'h2F;
    endtask

    always @(posedge clk) begin
        if (rst) model_reset();
        else begin
            m_clr = (we && addr == 8'h08) ? wdata[5:0] : 6'h0;
            m_irq = (m_st & m_ien) != 0;
            m_st  = (m_st & ~m_clr) | ev;
            if (we) begin
                case (addr)
                    8'h00: begin m_sw = wdata[0]; m_swsel = wdata[1]; end
                    8'h04: begin m_en = wdata[0]; m_ensel = wdata[1]; end
                    8'h0C: m_ien = wdata[5:0];
                    8'h10: begin m_preq = wdata[2:0]; m_lr = wdata[30]; m_lw = wdata[31]; end
                    8'h14: m_pol = wdata[3:0];
                    8'h18: m_us = wdata[9:0];
                    8'h1C: m_sp = wdata[7:0];
                    8'h3C: m_dsel = wdata[2:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] exp_read(logic [7:0] a);
        case (a)
            8'h00: return {30'd0, m_swsel, m_sw};
            8'h04: return {30'd0, m_ensel, m_en};
            8'h08: return {26'd0, m_st};
            8'h0C: return {26'd0, m_ien};
            8'h10: return {m_lw, m_lr, 27'd0, m_preq};
            8'h14: return {28'd0, m_pol};
            8'h18: return {22'd0, m_us};
            8'h1C: return {24'd0, m_sp};
            8'h38: return {14'd0, dsk, rxs, txs, 3'd0, trn};
            8'h3C: return {29'd0, m_dsel};
            8'h40: return dbg[32*m_dsel +: 32];
            default: return 32'd0;
        endcase
    endfunction

    function automatic string addr_tag(logic [7:0] a);
        case (a)
            8'h00, 8'h04: return "R2";
            8'h08: return "R3";
            8'h0C: return "R6";
            8'h10: return "R7";
            8'h14: return "R12";
            8'h18, 8'h1C: return "R8";
            8'h38: return "R9";
            8'h3C, 8'h40: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s t=%0t addr=%h actual=%h expected=%h", tag, $time, addr, act, exp);
        end
    endtask

    // compare everything on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            chk(phase_tag != "" ? phase_tag : addr_tag(addr), rdata, exp_read(addr));
            chk("R6 irq", 32'(irq), 32'(m_irq));
            chk("R2 swreset_out", 32'(sr_o), 32'(m_swsel ? m_sw : hw_sr));
            chk("R2 enable_out", 32'(en_o), 32'(m_ensel ? m_en : hw_en));
            chk("R7 outputs", {27'd0, lw_o, lr_o, preq_o}, {27'd0, m_lw, m_lr, m_preq});
            chk("R12 err_policy", 32'(pol_o), 32'(m_pol));
            chk("R8 us_tick_count", 32'(us_o), 32'(m_us));
            chk("R8 short_pkt_max", 32'(sp_o), 32'(m_sp));
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog: actual cycles=%0d expected below limit", cyc);
            summary();
            $finish;
        end
    end

    task automatic step();
        @(posedge clk); #2ns;
        we = 0; ev = '0;
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d, logic [5:0] e = '0);
        @(posedge clk); #2ns;
        we = 1; addr = a; wdata = d; ev = e;
        @(posedge clk); #2ns;
        we = 0; ev = '0;
    endtask

    task automatic pulse(logic [5:0] e);
        @(posedge clk); #2ns;
        ev = e;
        @(posedge clk); #2ns;
        ev = '0;
    endtask

    initial begin
        for (int k = 0; k < 8; k++) dbg[32*k +: 32] = $urandom;
        trn = 5'h15; txs = 4'h9; rxs = 4'h6; dsk = 2'h2;
        repeat (3) @(posedge clk);
        #2ns rst = 0;

        // R1: reset values, no writes
        phase_tag = "R1";
        for (int a = 0; a <= 'h40; a += 4) begin addr = 8'(a); step(); end
        phase_tag = "";

        // R2: logic source then register source
        addr = 8'h00;
        wr(8'h00, 32'h0);
        hw_sr = 1; step(); hw_sr = 0; step();
        wr(8'h00, 32'h2); hw_sr = 1; step(); hw_sr = 0; step();
        wr(8'h00, 32'h3); step();
        wr(8'h04, 32'h0); hw_en = 1; step();
        wr(8'h04, 32'h2); step();
        wr(8'h04, 32'h3); hw_en = 0; step();

        // R3: each event line on its own
        addr = 8'h08;
        for (int b = 0; b < 6; b++) begin pulse(6'(1 << b)); step(); end

        // R4: partial clear leaves other bits
        phase_tag = "R4";
        wr(8'h08, 32'h05); step();
        wr(8'h08, 32'h00); step();
        wr(8'h08, 32'hFFFF_FFFF); step();

        // R5: clear and pulse collide
        phase_tag = "R5";
        wr(8'h08, 32'h3F, 6'h3F); step(); step();
        wr(8'h08, 32'h3F, 6'h0A); step();
        wr(8'h08, 32'h3F); step();
        phase_tag = "";

        // R6: enables gate the interrupt
        pulse(6'h10); step(); step();
        wr(8'h0C, 32'h10); step(); step();
        wr(8'h0C, 32'h00); step();
        wr(8'h08, 32'h3F); wr(8'h0C, 32'h3F); step();

        // R7, R8, R12
        addr = 8'h10; wr(8'h10, 32'hFFFF_FFFF); step(); wr(8'h10, 32'h4000_0005); step();
        addr = 8'h18; wr(8'h18, 32'hFFFF_FFFF); step();
        addr = 8'h1C; wr(8'h1C, 32'hFFFF_FFFF); step();
        addr = 8'h14; wr(8'h14, 32'hA); step();

        // R9: read-only state word
        addr = 8'h38; wr(8'h38, 32'hFFFF_FFFF); step();
        trn = 5'h1F; txs = 4'hF; rxs = 4'hF; dsk = 2'h3; step();

        // R10: every debug group
        for (int s = 0; s < 8; s++) begin
            wr(8'h3C, 32'hFFFF_FFF8 | 32'(s));
            addr = 8'h40; step();
            wr(8'h40, 32'h0); step();
        end

        // R11: unmapped offsets
        wr(8'h44, 32'hFFFF_FFFF); addr = 8'h44; step();
        wr(8'h80, 32'hFFFF_FFFF); addr = 8'h80; step();
        wr(8'h02, 32'hFFFF_FFFF); addr = 8'h02; step();
        wr(8'h0A, 32'hFFFF_FFFF); addr = 8'h0A; step();

        // mixed random traffic
        for (int n = 0; n < 3000; n++) begin
            @(posedge clk); #2ns;
            we    = ($urandom % 3) == 0;
            addr  = ($urandom % 8 == 0) ? 8'($urandom) : 8'(4 * ($urandom % 18));
            wdata = ($urandom % 4 == 0) ? 32'hFFFF_FFFF : $urandom;
            ev    = 6'($urandom) & 6'($urandom) & 6'($urandom);
            hw_sr = 1'($urandom); hw_en = 1'($urandom);
            trn = 5'($urandom); txs = 4'($urandom); rxs = 4'($urandom); dsk = 2'($urandom);
        end
        step(); step();
        summary();
        $finish;
    end
endmodule